// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block is the arithmetic and logic unit of a small accumulator-based controller. Each cycle it takes the accumulator value, a second 8-bit operand, the carry flag and the auxiliary-carry flag, together with a 4-bit operation code from the instruction decoder. From these it produces an 8-bit result and new values for both flags. The supported functions are:

- addition, with or without the incoming carry;
- AND, OR and exclusive-OR;
- increment, decrement and complement of the accumulator;
- circular rotates and rotates through carry;
- an exchange of the two nibbles;
- a correction step that turns the binary sum of two packed-BCD bytes back into packed BCD.

The function logic is purely combinational. A parameter `REG_OUT` chooses whether the result and flags leave the block directly or through one register stage. The default is registered, which gives one cycle of latency. There is no subtract operation. The decoder's program forms `acc - x` as complement, add, complement.

Top module: `acc_alu`

## Requirements
- R1: With `REG_OUT` = 1, `res`, `cy_out` and `ac_out` are 0 while `rst_n` is low. After reset, each output shows the function of the inputs present at the previous rising clock edge.
- R2: Code 0 (add) gives `res` = (acc + opnd) mod 256. `cy_out` is the carry out of bit 7, and `ac_out` is the carry out of bit 3 into bit 4.
- R3: Code 1 (add with carry) behaves as R2 but also adds `cy_in`, both in the result and in both carries.
- R4: Codes 2 (AND), 3 (OR) and 4 (XOR) combine acc and opnd bitwise. They leave `cy_out` = `cy_in` and `ac_out` = `ac_in`.
- R5: Code 5 gives acc+1, code 6 gives acc-1 and code 7 gives ~acc, each modulo 256. Both flags pass through unchanged.
- R6: Code 8 rotates acc left circularly and code 10 rotates it right circularly; both leave the carry unchanged. Code 9 gives {acc[6:0], cy_in} with `cy_out` = acc[7]. Code 11 gives {cy_in, acc[7:1]} with `cy_out` = acc[0]. All rotates pass `ac_in` through.
- R7: Code 12 returns {acc[3:0], acc[7:4]} with both flags unchanged.
- R8: Code 13 (decimal adjust) works in two steps.
  - Step one: if acc[3:0] > 9 or `ac_in` = 1, add 0x06 to form a 9-bit value t.
  - Step two: if t[7:4] > 9, t[8] = 1 or `cy_in` = 1, add 0x60 to t[7:0].
  - `cy_out` is 1 exactly when step two applies. `ac_out` = `ac_in`.
- R9: Code 7, then code 0 with operand b, then code 7 again leaves (a - b) mod 256 when the accumulator starts at a.
- R10: Codes 14 and 15 return acc unchanged with both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 4 | Operation code |
| acc | input | 8 | Accumulator operand |
| opnd | input | 8 | Second operand |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| res | output | 8 | Result |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary-carry flag |

## Verification
The two corrections of decimal adjust can both apply in one operation, because the low-nibble fix may push the high nibble past 9 or out of bit 7. The bench provokes this with accumulator values such as 0x9A and 0xFA, and with the carry input set on an already-valid byte. A behavioural model compares the result and the carry on every such vector. Carry-in addition, where a carry chain runs through both nibbles at once, is covered by 0xFF + 0x00 with the carry input set. The bench checks that both the auxiliary carry and the carry rise.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] op,
  input  logic [7:0] acc,
  input  logic [7:0] opnd,
  input  logic       cy_in,
  input  logic       ac_in,
  output logic [7:0] res,
  output logic       cy_out,
  output logic       ac_out
);

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDC = 4'd1;
  localparam logic [3:0] OP_AND  = 4'd2;
  localparam logic [3:0] OP_OR   = 4'd3;
  localparam logic [3:0] OP_XOR  = 4'd4;
  localparam logic [3:0] OP_INC  = 4'd5;
  localparam logic [3:0] OP_DEC  = 4'd6;
  localparam logic [3:0] OP_CPL  = 4'd7;
  localparam logic [3:0] OP_RL   = 4'd8;
  localparam logic [3:0] OP_RLC  = 4'd9;
  localparam logic [3:0] OP_RR   = 4'd10;
  localparam logic [3:0] OP_RRC  = 4'd11;
  localparam logic [3:0] OP_SWP  = 4'd12;
  localparam logic [3:0] OP_DAJ  = 4'd13;

  wire       add_c = (op == OP_ADDC) & cy_in;
  wire [8:0] sum   = {1'b0, acc} + {1'b0, opnd} + {8'd0, add_c};
  wire [4:0] lsum  = {1'b0, acc[3:0]} + {1'b0, opnd[3:0]} + {4'd0, add_c};

  wire       lo_fix = (acc[3:0] > 4'd9) | ac_in;
  wire [8:0] da1    = {1'b0, acc} + (lo_fix ? 9'h006 : 9'h000);
  wire       hi_fix = (da1[7:4] > 4'd9) | da1[8] | cy_in;
  wire [7:0] da2    = da1[7:0] + (hi_fix ? 8'h60 : 8'h00);

  logic [7:0] n_res;
  logic       n_cy, n_ac;

  always_comb begin
    n_res = acc;
    n_cy  = cy_in;
    n_ac  = ac_in;
    case (op)
      OP_ADD, OP_ADDC: begin n_res = sum[7:0]; n_cy = sum[8]; n_ac = lsum[4]; end
      OP_AND: n_res = acc & opnd;
      OP_OR:  n_res = acc | opnd;
      OP_XOR: n_res = acc ^ opnd;
      OP_INC: n_res = acc + 8'd1;
      OP_DEC: n_res = acc - 8'd1;
      OP_CPL: n_res = ~acc;
      OP_RL:  n_res = {acc[6:0], acc[7]};
      OP_RLC: begin n_res = {acc[6:0], cy_in}; n_cy = acc[7]; end
      OP_RR:  n_res = {acc[0], acc[7:1]};
      OP_RRC: begin n_res = {cy_in, acc[7:1]}; n_cy = acc[0]; end
      OP_SWP: n_res = {acc[3:0], acc[7:4]};
      OP_DAJ: begin n_res = da2; n_cy = hi_fix; end
      default: ;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res    <= 8'h00;
          cy_out <= 1'b0;
          ac_out <= 1'b0;
        end else begin
          res    <= n_res;
          cy_out <= n_cy;
          ac_out <= n_ac;
        end
      end

      assert_logic_keeps_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_AND || op == OP_OR || op == OP_XOR) |=> (cy_out == $past(cy_in) && ac_out == $past(ac_in)));

      assert_add_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD) |=> (!cy_out || res < $past(acc)));

      assert_swap_bits_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SWP || op == OP_RL || op == OP_RR) |=> ($countones(res) == $countones($past(acc))));

      assert_inc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC) |=> (8'(res - $past(acc)) == 8'd1));

      assert_da_keeps_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DAJ && cy_in) |=> cy_out);

      assert_rlc_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RLC) |=> (res[0] == $past(cy_in) && cy_out == $past(acc[7])));

      assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (res == 8'h00 && !cy_out && !ac_out));
    end else begin : g_comb
      assign res    = n_res;
      assign cy_out = n_cy;
      assign ac_out = n_ac;
    end
  endgenerate

endmodule

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] acc = 8'd0, opnd = 8'd0;
  logic       cy_in = 1'b0, ac_in = 1'b0;
  logic [7:0] res;
  logic       cy_out, ac_out;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  acc_alu uut (.clk(clk), .rst_n(rst_n), .op(op), .acc(acc), .opnd(opnd),
               .cy_in(cy_in), .ac_in(ac_in), .res(res), .cy_out(cy_out), .ac_out(ac_out));

  function automatic logic [9:0] model(int o, int a, int b, int c, int x);
    int r = a, cy = c, ax = x, t, lo;
    case (o)
      0, 1: begin
        t  = a + b + ((o == 1) ? c : 0);
        lo = (a % 16) + (b % 16) + ((o == 1) ? c : 0);
        r = t % 256; cy = (t >= 256); ax = (lo >= 16);
      end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = (a + 1) % 256;
      6: r = (a + 255) % 256;
      7: r = 255 - a;
      8: r = ((a * 2) % 256) + a / 128;
      9: begin r = ((a * 2) % 256) + c; cy = a / 128; end
      10: r = a / 2 + (a % 2) * 128;
      11: begin r = a / 2 + c * 128; cy = a % 2; end
      12: r = (a % 16) * 16 + a / 16;
      13: begin
        t = a;
        if ((a % 16) > 9 || x == 1) t = t + 6;
        if (((t / 16) % 16) > 9 || t >= 256 || c == 1) begin
          r = ((t % 256) + 96) % 256; cy = 1;
        end else begin
          r = t % 256; cy = 0;
        end
      end
      default: ;
    endcase
    return {cy[0], ax[0], r[7:0]};
  endfunction

  function automatic string tag(int o);
    case (o)
      0: return "R2";
      1: return "R3";
      2, 3, 4: return "R4";
      5, 6, 7: return "R5";
      8, 9, 10, 11: return "R6";
      12: return "R7";
      13: return "R8";
      default: return "R10";
    endcase
  endfunction

  logic [9:0] exp_q[$];
  string      tag_q[$];

  task automatic check(string t, logic [9:0] got, logic [9:0] expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s got cy=%b ac=%b res=%02h expected cy=%b ac=%b res=%02h",
               t, got[9], got[8], got[7:0], expv[9], expv[8], expv[7:0]);
    end
  endtask

  // one op per clock; result is compared on the following falling edge
  task automatic issue(int o, int a, int b, int c, int x);
    @(negedge clk);
    if (exp_q.size() > 0) check(tag_q.pop_front(), {cy_out, ac_out, res}, exp_q.pop_front());
    op = 4'(o); acc = 8'(a); opnd = 8'(b); cy_in = c[0]; ac_in = x[0];
    exp_q.push_back(model(o, a, b, c, x));
    tag_q.push_back(tag(o));
  endtask

  task automatic drain();
    @(negedge clk);
    if (exp_q.size() > 0) check(tag_q.pop_front(), {cy_out, ac_out, res}, exp_q.pop_front());
  endtask

  task automatic single(int o, int a, int b, int c, int x, output logic [7:0] r);
    issue(o, a, b, c, x);
    drain();
    r = res;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    op = 4'd5; acc = 8'hAA; cy_in = 1'b1; ac_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {cy_out, ac_out, res}, 10'd0);
    rst_n = 1'b1;
    issue(0, 8'h0F, 8'h01, 0, 0);    // R2 aux carry only
    issue(0, 8'hF0, 8'h20, 0, 0);    // R2 carry only
    issue(1, 8'hFF, 8'h00, 1, 0);    // R3 carry in through both nibbles
    issue(1, 8'h12, 8'h34, 0, 1);    // R3 carry in clear
    issue(2, 8'hF0, 8'h3C, 1, 1);    // R4
    issue(4, 8'hFF, 8'h0F, 0, 1);    // R4
    issue(5, 8'hFF, 8'h00, 0, 0);    // R5 wraps, carry kept clear
    issue(6, 8'h00, 8'h00, 1, 0);    // R5 wraps
    issue(9, 8'h80, 8'h00, 0, 0);    // R6
    issue(11, 8'h01, 8'h00, 1, 0);   // R6
    issue(8, 8'h81, 8'h00, 0, 0);    // R6 carry untouched
    issue(12, 8'h3C, 8'h00, 1, 1);   // R7
    issue(13, 8'h9A, 8'h00, 0, 0);   // R8 both steps
    issue(13, 8'hFA, 8'h00, 0, 0);   // R8 step one overflows
    issue(13, 8'h45, 8'h00, 1, 0);   // R8 carry forces step two
    issue(13, 8'h38, 8'h00, 0, 1);   // R8 aux forces step one
    issue(13, 8'h42, 8'h00, 0, 0);   // R8 no correction
    issue(14, 8'h5A, 8'h77, 1, 0);   // R10
    issue(15, 8'hA5, 8'h77, 0, 1);   // R10
    for (int i = 0; i < 3000; i++)
      issue(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 1)), int'($urandom_range(0, 1)));
    drain();
    for (int i = 0; i < 40; i++) begin
      int a = int'($urandom_range(0, 255));
      int b = (i == 0) ? 0 : (i == 1) ? 255 : int'($urandom_range(0, 255));
      single(7, a, 0, 0, 0, r);
      single(0, r, b, 0, 0, r);
      single(7, r, 0, 0, 0, r);
      check("R9", {2'b00, r}, {2'b00, 8'((a - b + 256) % 256)});
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule